// File: doc/BRIEF.md
# System Clock Source Switching Controller

This block picks the system clock from three sources: a primary oscillator, a low-frequency secondary oscillator and an internal oscillator. A 2-bit select input chooses the source. A start-up timer counts primary cycles until a crystal-type primary can be trusted. A two-speed sequencer lets the system run on the internal clock while that timer counts, and moves it to the primary clock when the timer expires. When two-speed start-up is off, the output clock is held low until the primary is ready.

An activity monitor watches each external source using the internal clock as its reference. When fail-safe is enabled and the selected external source stops toggling, the controller falls back to the internal clock and raises a flag. The flag stays set until the next reset. Every change of source goes through per-source gating cells. Each cell turns its clock off on the low phase. A new cell is released only after all other cells report they are off.

The control logic runs on the internal clock, and `wake_i` is synchronous to it. The primary-crystal flag and both enables are quasi-static configuration inputs.

Top module: `sysclk_mux_ctrl`

## Requirements
- R1: While `rst_ni` is low, `ost_done_o` and `failsafe_o` are 0 and `clk_o` stays low. The internal select register resets to 00, which is the primary source.
- R2: Select encoding: 00 picks the primary clock, 01 the secondary clock, and both 10 and 11 pick the internal clock.
- R3: With a crystal primary, `ost_done_o` rises only after 1024 primary rising edges following reset or wake. It becomes visible within three internal clock cycles after the 1024th edge.
- R4: The move to the primary clock waits for 1024+8 primary edges, and `ost_done_o` is always 1 while the primary is marked ready.
- R5: With two-speed enabled and select 00, `clk_o` follows the internal clock during start-up and then follows the primary clock.
- R6: With two-speed disabled and select 00, `clk_o` stays low until the primary is ready.
- R7: With a non-crystal primary, there is no start-up count: `ost_done_o` and the primary handover follow within a few cycles of reset.
- R8: A wake event clears `ost_done_o` at once and restarts the start-up count. With two-speed enabled, the system runs on the internal clock until the count expires again.
- R9: With fail-safe enabled, if the selected external source shows no edge for 64 internal clock cycles, `clk_o` switches to the internal clock and `failsafe_o` rises. Both stay so until reset, whatever the select value.
- R10: With fail-safe disabled, a stopped source is not replaced and `failsafe_o` stays 0.
- R11: A stopped source that is not selected has no effect: `failsafe_o` stays 0 and the selected clock keeps running.
- R12: At most one source gate is enabled at any time. Gates change state only on the low phase of their own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri_i | input | 1 | Primary oscillator clock |
| clk_sec_i | input | 1 | Low-frequency secondary oscillator clock |
| clk_int_i | input | 1 | Internal oscillator clock, also the control and monitor reference |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Source select: 00 primary, 01 secondary, 1x internal |
| two_speed_i | input | 1 | Run from internal clock during primary start-up |
| failsafe_en_i | input | 1 | Enable fallback on a stopped external source |
| pri_xtal_i | input | 1 | Primary is crystal type and needs start-up timing |
| wake_i | input | 1 | Wake-up event, one internal-clock cycle pulse |
| clk_o | output | 1 | Selected system clock |
| ost_done_o | output | 1 | Start-up timer has expired |
| failsafe_o | output | 1 | Fail-safe fallback is active |

## Verification
The bench identifies the active source by counting `clk_o` edges over a fixed window. It checks the source at each point of interest.

It checks `ost_done_o` just before and just after the 1024-edge mark. A timer that is off by the settle count, or that ignores the crystal flag, fails one of these checks. It stops the primary while the secondary or internal clock is selected. A monitor that ignored the select would then raise `failsafe_o` wrongly.

It stops the selected source with fail-safe on and with fail-safe off. It then changes the select after fallback. A controller that lost stickiness, or deadlocked waiting for a dead clock to drop its gate, would show the wrong source or a silent output. It also sends a wake pulse after the handover. A stale ready flag crossing back would leave the primary running instead of the internal clock.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned NSRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2,
    SRC_OFF = 2'd3
  } src_e;
endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sysclk_ost.sv
module sysclk_ost #(
  parameter int unsigned OST_CYC     = 1024,
  parameter int unsigned SETTLE_CYC  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xtal_i,
  input  logic restart_tgl_i,
  output logic done_o,
  output logic rdy_o,
  output logic ack_o
);
  localparam int unsigned TOTAL = OST_CYC + SETTLE_CYC;
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  logic          tgl_s, tgl_q, restart;
  logic [CW-1:0] cnt_q;

  sysclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (restart_tgl_i),
    .q_o   (tgl_s)
  );

  assign restart = tgl_s ^ tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      tgl_q <= tgl_s;
      if (restart)                 cnt_q <= '0;
      else if (!xtal_i)            cnt_q <= CW'(TOTAL);
      else if (cnt_q != CW'(TOTAL)) cnt_q <= cnt_q + 1'b1;
    end
  end

  // ack moves on the same edge that clears the count
  assign ack_o  = tgl_q;
  assign done_o = (cnt_q >= CW'(OST_CYC));
  assign rdy_o  = (cnt_q == CW'(TOTAL));
endmodule

// File: rtl/sysclk_mon.sv
module sysclk_mon #(
  parameter int unsigned FAIL_CYC    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_mon_i,
  input  logic clk_ref_i,
  input  logic rst_ni,
  output logic dead_o
);
  localparam int unsigned CW = $clog2(FAIL_CYC + 1);

  logic          tgl_q, tgl_s, prev_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge clk_mon_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  sysclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_act_sync (
    .clk_i (clk_ref_i),
    .rst_ni(rst_ni),
    .d_i   (tgl_q),
    .q_o   (tgl_s)
  );

  always_ff @(posedge clk_ref_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      idle_q <= '0;
    end else begin
      prev_q <= tgl_s;
      if (tgl_s ^ prev_q)              idle_q <= '0;
      else if (idle_q != CW'(FAIL_CYC)) idle_q <= idle_q + 1'b1;
    end
  end

  assign dead_o = (idle_q == CW'(FAIL_CYC));
endmodule

// File: rtl/sysclk_gate.sv
module sysclk_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic kill_i,
  output logic en_o,
  output logic gclk_o
);
  logic req_s, en_q;

  sysclk_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  // update on the falling edge so the gate only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= req_s;
  end

  assign en_o   = en_q & ~kill_i;
  assign gclk_o = clk_i & en_o;
endmodule

// File: rtl/sysclk_mux_ctrl.sv
module sysclk_mux_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned OST_CYC     = 1024,
  parameter int unsigned SETTLE_CYC  = 8,
  parameter int unsigned FAIL_CYC    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_pri_i,
  input  logic       clk_sec_i,
  input  logic       clk_int_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       two_speed_i,
  input  logic       failsafe_en_i,
  input  logic       pri_xtal_i,
  input  logic       wake_i,
  output logic       clk_o,
  output logic       ost_done_o,
  output logic       failsafe_o
);
  localparam int unsigned NMON = 2;

  logic [1:0]      sel_q;
  logic            wake_tgl_q, fs_q;
  logic            pri_done, pri_rdy, pri_ack;
  logic            done_s, rdy_s, ack_s;
  logic            busy, rdy_eff, fail_trig;
  logic [NMON-1:0] mon_clk, dead;
  logic [NSRC-1:0] src_clk, req, kill, en_eff, gclk;
  src_e            active;

  // ---------------- start-up timer (primary domain)
  sysclk_ost #(
    .OST_CYC    (OST_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ost (
    .clk_i        (clk_pri_i),
    .rst_ni       (rst_ni),
    .xtal_i       (pri_xtal_i),
    .restart_tgl_i(wake_tgl_q),
    .done_o       (pri_done),
    .rdy_o        (pri_rdy),
    .ack_o        (pri_ack)
  );

  sysclk_sync #(.W(3), .STAGES(SYNC_STAGES)) u_ost_sync (
    .clk_i (clk_int_i),
    .rst_ni(rst_ni),
    .d_i   ({pri_ack, pri_rdy, pri_done}),
    .q_o   ({ack_s, rdy_s, done_s})
  );

  // a restart in flight masks the stale status coming back
  assign busy       = wake_tgl_q ^ ack_s;
  assign rdy_eff    = rdy_s & ~busy;
  assign ost_done_o = done_s & ~busy;

  // ---------------- activity monitors (internal domain reference)
  assign mon_clk = {clk_sec_i, clk_pri_i};

  for (genvar m = 0; m < NMON; m++) begin : g_mon
    sysclk_mon #(
      .FAIL_CYC   (FAIL_CYC),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
      .clk_mon_i(mon_clk[m]),
      .clk_ref_i(clk_int_i),
      .rst_ni   (rst_ni),
      .dead_o   (dead[m])
    );
  end

  assign fail_trig = ((sel_q == 2'b00) & dead[SRC_PRI]) |
                     ((sel_q == 2'b01) & dead[SRC_SEC]);

  // ---------------- control (internal domain)
  always_ff @(posedge clk_int_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q      <= 2'b00;
      wake_tgl_q <= 1'b0;
      fs_q       <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (wake_i)                    wake_tgl_q <= ~wake_tgl_q;
      if (failsafe_en_i && fail_trig) fs_q       <= 1'b1;
    end
  end

  assign failsafe_o = fs_q;

  always_comb begin
    if (fs_q) begin
      active = SRC_INT;
    end else begin
      unique case (sel_q)
        2'b00:   active = rdy_eff ? SRC_PRI : (two_speed_i ? SRC_INT : SRC_OFF);
        2'b01:   active = SRC_SEC;
        default: active = SRC_INT;
      endcase
    end
  end

  // ---------------- glitch-free gating
  assign src_clk = {clk_int_i, clk_sec_i, clk_pri_i};
  // after fallback the external gates are masked; their clocks may be dead
  assign kill    = {1'b0, fs_q, fs_q};

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign req[g] = (active == src_e'(g)) &&
                    ((en_eff & ~(NSRC'(1) << g)) == '0);

    sysclk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_i (src_clk[g]),
      .rst_ni(rst_ni),
      .req_i (req[g]),
      .kill_i(kill[g]),
      .en_o  (en_eff[g]),
      .gclk_o(gclk[g])
    );
  end

  assign clk_o = |gclk;
endmodule

// File: rtl/sysclk_mux_ctrl_chk.sv
module sysclk_mux_ctrl_chk
  import sysclk_pkg::*;
(
  input logic            clk_int_i,
  input logic            rst_ni,
  input logic            failsafe_o,
  input logic            ost_done_o,
  input logic            rdy_eff,
  input logic [NSRC-1:0] en_eff
);
  AST_ONE_GATE: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    $onehot0(en_eff));                                            // R12

  AST_DONE_BEFORE_READY: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    rdy_eff |-> ost_done_o);                                      // R4

  AST_FS_STICKY: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    failsafe_o |=> failsafe_o);                                   // R9

  AST_FS_RUNS_INT: assert property (@(posedge clk_int_i) disable iff (!rst_ni)
    (failsafe_o && $past(failsafe_o, 4)) |-> en_eff[SRC_INT]);    // R9
endmodule

bind sysclk_mux_ctrl sysclk_mux_ctrl_chk u_chk (
  .clk_int_i (clk_int_i),
  .rst_ni    (rst_ni),
  .failsafe_o(failsafe_o),
  .ost_done_o(ost_done_o),
  .rdy_eff   (rdy_eff),
  .en_eff    (en_eff)
);

// File: tb/sim_sysclk_mux_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_mux_ctrl;
  localparam int C_PRI = 0, C_SEC = 1, C_INT = 2, C_OFF = 3;

  logic clk = 1'b0;       // 250 MHz, doubles as primary oscillator
  always #2 clk = ~clk;
  logic clk_int = 1'b0;
  always #13 clk_int = ~clk_int;
  logic sec_base = 1'b0;
  always #7 sec_base = ~sec_base;

  logic pri_run = 1'b1, sec_run = 1'b1;
  wire  clk_pri = clk & pri_run;
  wire  clk_sec = sec_base & sec_run;

  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       ts = 1'b1, fs_en = 1'b1, xtal = 1'b1, wake = 1'b0;
  wire        clk_o, ost_done, failsafe;

  sysclk_mux_ctrl u0 (
    .clk_pri_i    (clk_pri),
    .clk_sec_i    (clk_sec),
    .clk_int_i    (clk_int),
    .rst_ni       (rst_n),
    .sel_i        (sel),
    .two_speed_i  (ts),
    .failsafe_en_i(fs_en),
    .pri_xtal_i   (xtal),
    .wake_i       (wake),
    .clk_o        (clk_o),
    .ost_done_o   (ost_done),
    .failsafe_o   (failsafe)
  );

  int  checks = 0, errors = 0, edge_cnt = 0;
  time t_rel = 0;
  bit  mon_busy = 0, finished = 0;

  always @(posedge clk_o) edge_cnt++;

  typedef struct {
    string tag;
    int    src;
    int    done;
    int    fs;
  } item_t;
  item_t q[$];

  function automatic int classify(int n);
    if (n <= 2)                return C_OFF;
    if (n >= 8 && n <= 26)     return C_INT;
    if (n >= 28 && n <= 60)    return C_SEC;
    if (n >= 90)               return C_PRI;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against measured output
  initial begin
    forever begin
      item_t it;
      int    start;
      wait (q.size() > 0);
      it       = q.pop_front();
      mon_busy = 1;
      start    = edge_cnt;
      #520;
      @(negedge clk_int);
      chk({it.tag, " source"}, classify(edge_cnt - start), it.src);
      chk({it.tag, " ost_done"}, int'(ost_done), it.done);
      chk({it.tag, " failsafe"}, int'(failsafe), it.fs);
      mon_busy = 0;
    end
  end

  task automatic expect_win(string tag, int src, int done, int fs);
    item_t it;
    it.tag = tag; it.src = src; it.done = done; it.fs = fs;
    q.push_back(it);
    #1;
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic wait_rel(time ns);
    if ($time < t_rel + ns) #(t_rel + ns - $time);
  endtask

  task automatic do_reset(logic t, logic x, logic f);
    @(negedge clk);
    rst_n = 1'b0; sel = 2'b00; ts = t; xtal = x; fs_en = f;
    pri_run = 1'b1; sec_run = 1'b1;
    repeat (3) @(posedge clk_int);
    expect_win("R1 in reset", C_OFF, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    t_rel = $time;
  endtask

  task automatic set_pri(logic on);
    @(negedge clk); pri_run = on;
  endtask

  task automatic set_sec(logic on);
    @(negedge sec_base); sec_run = on;
  endtask

  task automatic pulse_wake();
    @(negedge clk_int); wake = 1'b1;
    @(negedge clk_int); wake = 1'b0;
  endtask

  initial begin
    // two-speed start-up with crystal primary
    do_reset(1, 1, 1);
    #200;
    expect_win("R5 internal during start-up", C_INT, 0, 0);
    wait_rel(4080);
    chk("R3 done low before 1024 edges", int'(ost_done), 0);
    wait_rel(4200);
    chk("R3 done high after 1024 edges", int'(ost_done), 1);
    wait_rel(5000);
    expect_win("R4 R5 primary after start-up", C_PRI, 1, 0);

    // select encoding
    sel = 2'b01; #300;
    expect_win("R2 sel 01", C_SEC, 1, 0);
    sel = 2'b10; #300;
    expect_win("R2 sel 10", C_INT, 1, 0);
    sel = 2'b11; #300;
    expect_win("R2 sel 11", C_INT, 1, 0);

    // unselected source stops: ignored
    set_pri(0); #2500;
    expect_win("R11 unselected primary stopped", C_INT, 1, 0);
    set_pri(1); #300;
    sel = 2'b00; #400;
    expect_win("R2 sel 00", C_PRI, 1, 0);

    // selected primary stops with fail-safe on
    set_pri(0); #2500;
    expect_win("R9 primary fail fallback", C_INT, 1, 1);
    sel = 2'b01; #300;
    expect_win("R9 fallback sticky", C_INT, 1, 1);
    set_pri(1);

    // fail-safe disabled
    do_reset(1, 1, 0);
    wait_rel(5000);
    expect_win("R5 primary fs off", C_PRI, 1, 0);
    set_pri(0); #2500;
    expect_win("R10 no fallback", C_OFF, 1, 0);
    set_pri(1);

    // secondary failure
    do_reset(1, 1, 1);
    wait_rel(5000);
    sel = 2'b01; #300;
    expect_win("R2 secondary running", C_SEC, 1, 0);
    set_sec(0); #2500;
    expect_win("R9 secondary fail fallback", C_INT, 1, 1);
    set_sec(1);

    // two-speed disabled: hold off
    do_reset(0, 1, 1);
    #50;
    expect_win("R6 held off during start-up", C_OFF, 0, 0);
    wait_rel(5000);
    expect_win("R6 primary after start-up", C_PRI, 1, 0);

    // non-crystal primary
    do_reset(1, 0, 1);
    #500;
    expect_win("R7 no start-up count", C_PRI, 1, 0);

    // wake restarts start-up
    do_reset(1, 1, 1);
    wait_rel(5000);
    expect_win("R8 primary before wake", C_PRI, 1, 0);
    pulse_wake();
    #200;
    expect_win("R8 internal after wake", C_INT, 0, 0);
    #5000;
    expect_win("R8 primary after restart", C_PRI, 1, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule